// File: doc/BRIEF.md
# Multicast Port Flush Engine

This block is a background walker for a switch address lookup table. When it gets a command, it visits every table index in turn, from the lowest to the highest. It removes a chosen set of egress ports from multicast address entries. If an entry loses its last port, the entry is released. The command carries three things: a port mask, a VLAN id, and a flag. When the flag is set, the VLAN id is ignored and entries on every VLAN are processed.

The table itself sits outside the block, behind a simple synchronous memory port. A read issued in one cycle returns its data on the next cycle, and writes are single-cycle. For each index the engine issues one read and evaluates the returned entry. It writes the entry back only when something actually changes. Skipped entries cost two cycles and modified entries cost three. At the end of the walk a one-cycle done pulse is raised, and a count of the entries that were released is presented alongside it.

Top module: `mcast_flush_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, cmd_reject, tbl_rd_en and tbl_wr_en are 0 and freed_count is 0.
- R2: An accepted command makes busy 1 in the next cycle. The walk then reads each index exactly once, in ascending order from 0 to DEPTH-1.
- R3: Only entries whose kind field (bits 61:60) is 1 (address) or 3 (VLAN-qualified address) are candidates. Kinds 0 and 2 are never written.
- R4: With cmd_all_vlans low, an entry whose VLAN field (bits 59:48) differs from cmd_vid is not written. With cmd_all_vlans high, the VLAN field is not compared.
- R5: An entry with the group bit (bit 40) clear, or with the pinned bit (bit 65) set, is not written.
- R6: An entry whose address field (bits 47:0) is all ones is never written.
- R7: An entry whose member field (bits 66 upward, one bit per port, bit 66 = port 0) shares no bit with cmd_ports is not written. A command with cmd_ports of zero changes nothing.
- R8: An entry that passes all filters and keeps at least one port is written back with the member field equal to its old value with the cmd_ports bits cleared. Every other bit is unchanged.
- R9: An entry that passes all filters and has no member left is written back with its kind field set to 0 and all other bits unchanged. freed_count, cleared at command acceptance, equals the number of such entries.
- R10: cmd_valid while busy is ignored. cmd_reject is high for exactly the one cycle after it, and the running walk is not altered.
- R11: done is high for exactly one cycle after the last index has been handled, with busy already 0. freed_count holds its value until the next accepted command.
- R12: A write targets the index read two cycles earlier. Read and write are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start request, one cycle |
| cmd_ports | input | PORTS | Ports to remove from multicast entries |
| cmd_vid | input | 12 | VLAN id to restrict the walk to |
| cmd_all_vlans | input | 1 | Ignore cmd_vid and process all VLANs |
| busy | output | 1 | Walk in progress |
| cmd_reject | output | 1 | Pulse: a command arrived while busy |
| done | output | 1 | Pulse: walk finished |
| freed_count | output | $clog2(DEPTH+1) | Entries released by the last walk |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_addr | output | $clog2(DEPTH) | Table index for read and write |
| tbl_rd_data | input | 66+PORTS | Entry returned one cycle after the read |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_data | output | 66+PORTS | Entry to be written |

## Verification
A wrong filter decision leaves a visible mark on the table port. Either a write appears for an entry that should have been skipped, or an expected write with the narrowed or released entry is missing. Both show up within three cycles of that entry's read. A corrupted index counter shows up at the first read as an out-of-order tbl_addr. A counter that stops early or late moves the done pulse away from the cycle after index DEPTH-1. A wrong release tally is seen in freed_count when done is raised.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int KIND_LSB   = 60;
  localparam int VID_LSB    = 48;
  localparam int VID_W      = 12;
  localparam int MAC_W      = 48;
  localparam int GROUP_BIT  = 40;
  localparam int PINNED_BIT = 65;
  localparam int MEMBER_LSB = 66;

  typedef enum logic [1:0] {
    KIND_FREE      = 2'd0,
    KIND_ADDR      = 2'd1,
    KIND_VLAN      = 2'd2,
    KIND_VLAN_ADDR = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_CAPTURE,
    ST_WRITE
  } walk_state_e;
endpackage

// File: rtl/mcf_index_walker.sv
module mcf_index_walker #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          advance,
  output logic [AW-1:0] idx,
  output logic          at_last
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) idx <= '0;
    else if (advance)   idx <= idx + 1'b1;
  end

  assign at_last = (idx == LAST_IDX);
endmodule

// File: rtl/mcf_entry_judge.sv
module mcf_entry_judge
  import mcf_pkg::*;
#(
  parameter int PORTS = 6,
  parameter int EW    = MEMBER_LSB + PORTS
) (
  input  logic [EW-1:0]    entry,
  input  logic [PORTS-1:0] drop_ports,
  input  logic [VID_W-1:0] vid,
  input  logic             all_vlans,
  output logic             need_write,
  output logic             release_it,
  output logic [EW-1:0]    new_entry
);
  kind_e            kind;
  logic             is_addr;
  logic             vid_ok;
  logic             bcast;
  logic [PORTS-1:0] members;
  logic [PORTS-1:0] remaining;
  logic             overlap;

  always_comb begin
    kind       = kind_e'(entry[KIND_LSB +: 2]);
    is_addr    = (kind == KIND_ADDR) || (kind == KIND_VLAN_ADDR);
    vid_ok     = all_vlans || (entry[VID_LSB +: VID_W] == vid);
    bcast      = &entry[MAC_W-1:0];
    members    = entry[MEMBER_LSB +: PORTS];
    overlap    = |(members & drop_ports);
    remaining  = members & ~drop_ports;
    need_write = is_addr && vid_ok && entry[GROUP_BIT] && !entry[PINNED_BIT]
                 && !bcast && overlap;
    release_it = need_write && (remaining == '0);
    new_entry  = entry;
    if (release_it) new_entry[KIND_LSB +: 2] = KIND_FREE;
    else            new_entry[MEMBER_LSB +: PORTS] = remaining;
  end
endmodule

// File: rtl/mcf_release_tally.sv
module mcf_release_tally #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          bump,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || restart) count <= '0;
    else if (bump)      count <= count + 1'b1;
  end
endmodule

// File: rtl/mcast_flush_engine.sv
module mcast_flush_engine
  import mcf_pkg::*;
#(
  parameter int PORTS = 6,
  parameter int DEPTH = 64,
  localparam int EW   = MEMBER_LSB + PORTS,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [PORTS-1:0] cmd_ports,
  input  logic [VID_W-1:0] cmd_vid,
  input  logic             cmd_all_vlans,
  output logic             busy,
  output logic             cmd_reject,
  output logic             done,
  output logic [CW-1:0]    freed_count,
  output logic             tbl_rd_en,
  output logic [AW-1:0]    tbl_addr,
  input  logic [EW-1:0]    tbl_rd_data,
  output logic             tbl_wr_en,
  output logic [EW-1:0]    tbl_wr_data
);
  walk_state_e      state;
  logic [PORTS-1:0] hold_ports;
  logic [VID_W-1:0] hold_vid;
  logic             hold_all;
  logic             need_write;
  logic             release_it;
  logic [EW-1:0]    new_entry;
  logic             at_last;
  logic             accept;
  logic             advance;
  logic             bump;

  assign accept  = (state == ST_IDLE) && cmd_valid;
  assign advance = ((state == ST_CAPTURE) && !need_write && !at_last) ||
                   ((state == ST_WRITE) && !at_last);
  assign bump    = (state == ST_CAPTURE) && release_it;
  assign busy    = (state != ST_IDLE);

  mcf_index_walker #(.DEPTH(DEPTH), .AW(AW)) u_walk (
    .clk(clk), .rst(rst), .restart(accept), .advance(advance),
    .idx(tbl_addr), .at_last(at_last)
  );

  mcf_entry_judge #(.PORTS(PORTS), .EW(EW)) u_judge (
    .entry(tbl_rd_data), .drop_ports(hold_ports), .vid(hold_vid),
    .all_vlans(hold_all), .need_write(need_write), .release_it(release_it),
    .new_entry(new_entry)
  );

  mcf_release_tally #(.DEPTH(DEPTH), .CW(CW)) u_tally (
    .clk(clk), .rst(rst), .restart(accept), .bump(bump), .count(freed_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      hold_ports  <= '0;
      hold_vid    <= '0;
      hold_all    <= 1'b0;
      tbl_rd_en   <= 1'b0;
      tbl_wr_en   <= 1'b0;
      tbl_wr_data <= '0;
      done        <= 1'b0;
      cmd_reject  <= 1'b0;
    end else begin
      tbl_rd_en  <= 1'b0;
      tbl_wr_en  <= 1'b0;
      done       <= 1'b0;
      cmd_reject <= cmd_valid && (state != ST_IDLE);
      case (state)
        ST_IDLE: if (cmd_valid) begin
          hold_ports <= cmd_ports;
          hold_vid   <= cmd_vid;
          hold_all   <= cmd_all_vlans;
          tbl_rd_en  <= 1'b1;
          state      <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_CAPTURE;
        ST_CAPTURE: begin
          if (need_write) begin
            tbl_wr_en   <= 1'b1;
            tbl_wr_data <= new_entry;
            state       <= ST_WRITE;
          end else if (at_last) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            tbl_rd_en <= 1'b1;
            state     <= ST_ISSUE;
          end
        end
        ST_WRITE: begin
          if (at_last) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            tbl_rd_en <= 1'b1;
            state     <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcf_flush_checker.sv
module mcf_flush_checker
  import mcf_pkg::*;
#(
  parameter int PORTS = 6,
  parameter int DEPTH = 64,
  localparam int EW   = MEMBER_LSB + PORTS,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          busy,
  input logic          cmd_reject,
  input logic          done,
  input logic [CW-1:0] freed_count,
  input logic          tbl_rd_en,
  input logic [AW-1:0] tbl_addr,
  input logic          tbl_wr_en,
  input logic [EW-1:0] tbl_wr_data
);
  assert_one_access_R12: assert property (@(posedge clk) disable iff (rst)
    !(tbl_rd_en && tbl_wr_en));

  assert_write_follows_read_R12: assert property (@(posedge clk) disable iff (rst)
    tbl_wr_en |-> ($past(tbl_rd_en, 2) && tbl_addr == $past(tbl_addr, 2)));

  assert_read_while_busy_R2: assert property (@(posedge clk) disable iff (rst)
    tbl_rd_en |-> busy);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_reject_cause_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_reject |-> ($past(busy) && $past(cmd_valid)));

  assert_write_shape_R9: assert property (@(posedge clk) disable iff (rst)
    tbl_wr_en |-> (tbl_wr_data[KIND_LSB +: 2] == 2'd0 ||
                   tbl_wr_data[MEMBER_LSB +: PORTS] != '0));

  assert_tally_bound_R9: assert property (@(posedge clk) disable iff (rst)
    freed_count <= CW'(DEPTH));
endmodule

bind mcast_flush_engine mcf_flush_checker #(.PORTS(PORTS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy),
  .cmd_reject(cmd_reject), .done(done), .freed_count(freed_count),
  .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr), .tbl_wr_en(tbl_wr_en),
  .tbl_wr_data(tbl_wr_data)
);

// File: tb/sim_mcast_flush_engine.sv
module sim_mcast_flush_engine;
  localparam int P     = 6;
  localparam int DEPTH = 64;
  localparam int EW    = 66 + P;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [P-1:0] cmd_ports = '0;
  logic [11:0] cmd_vid = '0;
  logic cmd_all_vlans = 1'b0;
  logic busy, cmd_reject, done, tbl_rd_en, tbl_wr_en;
  logic [CW-1:0] freed_count;
  logic [AW-1:0] tbl_addr;
  logic [EW-1:0] tbl_rd_data, tbl_wr_data;

  always #4 clk = ~clk;

  mcast_flush_engine #(.PORTS(P), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ports(cmd_ports),
    .cmd_vid(cmd_vid), .cmd_all_vlans(cmd_all_vlans), .busy(busy),
    .cmd_reject(cmd_reject), .done(done), .freed_count(freed_count),
    .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr), .tbl_rd_data(tbl_rd_data),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_data(tbl_wr_data)
  );

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] stage [DEPTH];
  logic [EW-1:0] exp_mem [DEPTH];
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_idx = '0;
  logic [EW-1:0] ld_val = '0;
  int rd_total = 0, wr_total = 0, order_err = 0, wr_bad = 0;
  logic [AW-1:0] last_rd = AW'(DEPTH - 1);

  always @(posedge clk) begin
    if (ld_en) mem[ld_idx] <= ld_val;
    if (tbl_rd_en) begin
      tbl_rd_data <= mem[tbl_addr];
      rd_total <= rd_total + 1;
      if (tbl_addr != AW'(last_rd + 1'b1)) order_err <= order_err + 1;
      last_rd <= tbl_addr;
    end
    if (tbl_wr_en) begin
      mem[tbl_addr] <= tbl_wr_data;
      wr_total <= wr_total + 1;
      if (tbl_addr != last_rd) wr_bad <= wr_bad + 1;
    end
  end

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [EW-1:0] mk(input logic [1:0] kind, input logic [11:0] vid,
                                       input logic [47:0] mac, input bit pin,
                                       input logic [P-1:0] pm);
    logic [EW-1:0] e = '0;
    e[61:60] = kind; e[59:48] = vid; e[47:0] = mac; e[65] = pin; e[66 +: P] = pm;
    return e;
  endfunction

  // Expected outcome per entry, from the filtering and update rules
  function automatic logic [EW-1:0] model(input logic [EW-1:0] e, input logic [P-1:0] m,
                                          input logic [11:0] v, input bit all,
                                          output bit wr, output bit fr);
    logic [EW-1:0] r = e;
    logic [P-1:0] left;
    bit cand;
    cand = (e[61:60] == 2'd1 || e[61:60] == 2'd3) && (all || e[59:48] == v) &&
           e[40] && !e[65] && (e[47:0] != 48'hffff_ffff_ffff) && ((e[66 +: P] & m) != 0);
    left = e[66 +: P] & ~m;
    wr = cand;
    fr = cand && (left == 0);
    if (fr) r[61:60] = 2'd0;
    else if (cand) r[66 +: P] = left;
    return r;
  endfunction

  task automatic load_table();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = AW'(i); ld_val = stage[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_flush(input logic [P-1:0] m, input logic [11:0] v,
                           input bit all, input bit poke);
    int rd0, wr0, ord0, wb0, exp_wr, exp_fr, waited;
    bit w, f;
    rd0 = rd_total; wr0 = wr_total; ord0 = order_err; wb0 = wr_bad;
    exp_wr = 0; exp_fr = 0;
    for (int i = 0; i < DEPTH; i++) begin
      exp_mem[i] = model(mem[i], m, v, all, w, f);
      exp_wr += int'(w); exp_fr += int'(f);
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ports = m; cmd_vid = v; cmd_all_vlans = all;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    if (poke) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_ports = ~m; cmd_all_vlans = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(cmd_reject == 1'b1, "R10", "reject pulse", cmd_reject, 1);
      @(negedge clk);
      check(cmd_reject == 1'b0, "R10", "reject width", cmd_reject, 0);
    end
    waited = 0;
    while (!done && waited < 10 * DEPTH + 50) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, "R11", "done seen", done, 1);
    check(busy == 1'b0, "R11", "idle at done", busy, 0);
    check(freed_count == CW'(exp_fr), "R9", "freed count", freed_count, exp_fr);
    @(negedge clk);
    check(done == 1'b0, "R11", "done one cycle", done, 0);
    check(freed_count == CW'(exp_fr), "R11", "count held", freed_count, exp_fr);
    for (int i = 0; i < DEPTH; i++)
      check(mem[i] == exp_mem[i], "R8", $sformatf("entry %0d", i), mem[i], exp_mem[i]);
    check(wr_total - wr0 == exp_wr, "R3", "write count", wr_total - wr0, exp_wr);
    check(rd_total - rd0 == DEPTH, "R2", "read count", rd_total - rd0, DEPTH);
    check(order_err == ord0, "R2", "read order", order_err - ord0, 0);
    check(wr_bad == wb0, "R12", "write index", wr_bad - wb0, 0);
  endtask

  function automatic logic [EW-1:0] rand_entry();
    logic [47:0] mac;
    logic [11:0] vid;
    mac = {16'($urandom), $urandom};
    if ($urandom_range(7) == 0) mac = '1;
    else mac[40] = ($urandom_range(3) != 0);
    vid = ($urandom_range(1) == 0) ? 12'd5 : 12'($urandom_range(8));
    return mk(2'($urandom_range(3)), vid, mac, $urandom_range(7) == 0,
              P'($urandom));
  endfunction

  localparam logic [47:0] GRP = 48'h0100_5e00_0001;
  localparam logic [47:0] UNI = 48'h00aa_0000_0001;

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && cmd_reject == 0, "R1", "flags in reset",
          {busy, done, cmd_reject}, 0);
    check(tbl_rd_en == 0 && tbl_wr_en == 0, "R1", "strobes in reset",
          {tbl_rd_en, tbl_wr_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(freed_count == 0 && busy == 0, "R1", "after reset", {freed_count, busy}, 0);

    // Directed corner cases, command mask ports 0 and 1, VLAN 5
    for (int i = 0; i < DEPTH; i++) stage[i] = mk(2'd0, 12'd5, GRP, 0, 6'b000011);
    stage[0] = mk(2'd1, 12'd5, GRP, 0, 6'b000111);      // R8 narrow
    stage[1] = mk(2'd1, 12'd5, GRP, 0, 6'b000011);      // R9 release
    stage[2] = mk(2'd3, 12'd5, GRP, 0, 6'b000001);      // R9 release, VLAN-addr kind
    stage[3] = mk(2'd2, 12'd5, GRP, 0, 6'b111111);      // R3 VLAN kind
    stage[4] = mk(2'd1, 12'd9, GRP, 0, 6'b000011);      // R4 other VLAN
    stage[5] = mk(2'd1, 12'd5, UNI, 0, 6'b000011);      // R5 group bit clear
    stage[6] = mk(2'd1, 12'd5, GRP, 1, 6'b000011);      // R5 pinned
    stage[7] = mk(2'd1, 12'd5, '1, 0, 6'b000011);       // R6 broadcast
    stage[8] = mk(2'd1, 12'd5, GRP, 0, 6'b110000);      // R7 no overlap
    load_table();
    run_flush(6'b000011, 12'd5, 1'b0, 1'b0);
    check(mem[4] == stage[4], "R4", "other VLAN kept", mem[4], stage[4]);
    check(mem[6] == stage[6], "R5", "pinned kept", mem[6], stage[6]);
    check(mem[7] == stage[7], "R6", "broadcast kept", mem[7], stage[7]);
    check(mem[8] == stage[8], "R7", "disjoint kept", mem[8], stage[8]);
    check(mem[1][61:60] == 2'd0, "R9", "released kind", mem[1][61:60], 0);

    // All VLANs: entry 4 now qualifies; reject while busy
    load_table();
    run_flush(6'b000011, 12'd5, 1'b1, 1'b1);
    check(mem[4][61:60] == 2'd0, "R4", "all-VLAN release", mem[4][61:60], 0);

    // Empty port mask changes nothing
    run_flush('0, 12'd5, 1'b1, 1'b0);

    // Random tables and commands
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < DEPTH; i++) stage[i] = rand_entry();
      load_table();
      run_flush(P'($urandom), 12'd5, $urandom_range(1) == 1, r == 2);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule